// File: doc/BRIEF.md
# Block-transfer host register window

This block is the host-facing side of a block-transfer system interface used to pass management requests between a host processor and a baseboard controller. The host sees three byte-wide registers behind a two-bit address: a control and status byte, a data port, and an interrupt mask byte. Bytes written to the data port fill an inbound request buffer. Bytes read from it drain an outbound response buffer that the controller side has loaded.

The control byte carries the busy and attention handshake. Its bits act in different ways on a write of one: some clear a flag, one toggles a flag, and some trigger an action. The controller side sees a one-cycle request strobe when the host hands over a request. It reads the inbound bytes through an index port, writes the response through a write port, and reports a finished response or an asynchronous attention event with single-cycle pulses. A single level interrupt line goes to the host. The host can enable it while attention is already pending, and it then fires at once.

Top module: `bt_host_window`

## Requirements
- R1: After reset the control byte reads 0x00, the mask byte reads 0x00, `irq_o` is low, and a data-port read returns 0xFF.
- R2: Address 0 selects control, address 1 selects data and address 2 selects mask. A read at address 3 returns 0xFF and a write there changes nothing. Control bits 0, 1, 2 and 5 always read as zero.
- R3: A data-port write stores the byte at index `bmc_ib_count` only while that count is below the buffer depth (64). The count increments on every data write, saturating at all ones. Writing 1 to control bit 0 resets the count to zero.
- R4: A pulse on `bmc_rsp_valid` sets the outbound length to `bmc_rsp_len`, clamped to the depth, and rewinds the read pointer. Data-port reads return the loaded bytes in index order. After the last byte both pointer and length return to zero, and further reads return 0xFF. Writing 1 to control bit 1 rewinds the pointer to zero.
- R5: Writing 1 to control bit 2 sets the controller-busy flag (bit 7) and makes `bmc_req_o` high for exactly the following cycle.
- R6: Writing 1 to control bit 3 clears the response-attention flag, and writing 1 to bit 4 clears the event-attention flag. Writing 0 to either bit leaves that flag unchanged.
- R7: Writing 1 to control bit 6 inverts the host-busy flag. Writing 0 there leaves it unchanged.
- R8: `bmc_rsp_valid` clears controller-busy and sets response-attention (bit 3). `bmc_sms_set` sets event-attention (bit 4).
- R9: Mask bit 0 is interrupt enable and mask bit 1 is interrupt pending. If enable goes from 0 to 1 while either attention flag is set, pending is set. If enable goes from 1 to 0, pending is cleared.
- R10: A mask write with bit 1 set clears pending when it is set, and does nothing when it is clear. `irq_o` always equals pending.
- R11: A response or attention event sets pending only while the interrupt is enabled.
- R12: Pending is never set while enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of `host_rd` |
| irq_o | output | 1 | Level interrupt to the host |
| bmc_req_o | output | 1 | One-cycle strobe: request handed over |
| bmc_ib_idx | input | 6 | Inbound buffer read index |
| bmc_ib_byte | output | 8 | Inbound byte at `bmc_ib_idx` |
| bmc_ib_count | output | 8 | Number of data writes since the last clear |
| bmc_ob_we | input | 1 | Outbound buffer write enable |
| bmc_ob_idx | input | 6 | Outbound buffer write index |
| bmc_ob_byte | input | 8 | Outbound buffer write data |
| bmc_rsp_valid | input | 1 | Response loaded pulse |
| bmc_rsp_len | input | 7 | Response length in bytes |
| bmc_sms_set | input | 1 | Event-attention pulse |

## Verification
The assertions assume the host never asserts read and write in the same cycle, and that the controller side does not pulse `bmc_rsp_valid` while the host is reading the data port. The enable-rise and pending-clear properties apply only when no attention event arrives in the same cycle, because an event would set pending again. The bench issues one host access per cycle and drives controller pulses only between host accesses. Every response it loads is shorter than the buffer, so the clamp is never reached.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_DATA = 2'd1,
        OFS_MASK = 2'd2,
        OFS_NONE = 2'd3
    } bt_ofs_e;

    // control byte bit positions
    localparam int unsigned CB_RST_IN   = 0;
    localparam int unsigned CB_RST_OUT  = 1;
    localparam int unsigned CB_HOST_GO  = 2;
    localparam int unsigned CB_RSP_ATN  = 3;
    localparam int unsigned CB_EVT_ATN  = 4;
    localparam int unsigned CB_HOST_BSY = 6;
    localparam int unsigned CB_CTL_BSY  = 7;

    // mask byte bit positions
    localparam int unsigned MB_EN   = 0;
    localparam int unsigned MB_PEND = 1;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/bt_ib_buf.sv
module bt_ib_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [CNT_W-1:0]      cnt;
    } ib_state_t;

    ib_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (wr_en) begin
            if (st_q.cnt < CNT_W'(DEPTH)) begin
                st_d.mem[st_q.cnt[IDX_W-1:0]] = wr_byte;
            end
            if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_byte = st_q.mem[rd_idx];
    assign count   = st_q.cnt;

    AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (st_q.cnt != '0)) else $error("count stuck"); // R3
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0)) else $error("clear missed"); // R3
endmodule

// File: rtl/bt_ob_buf.sv
module bt_ob_buf #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned LEN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bmc_we,
    input  logic [IDX_W-1:0] bmc_idx,
    input  logic [7:0]       bmc_byte,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             pop,
    input  logic             rewind,
    output logic [7:0]       head_byte
);
    import bt_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [LEN_W-1:0]      len;
        logic [LEN_W-1:0]      ptr;
    } ob_state_t;

    ob_state_t  st_d, st_q;
    logic       avail;
    logic [LEN_W-1:0] ptr_inc;

    assign avail   = (st_q.ptr < st_q.len);
    assign ptr_inc = st_q.ptr + 1'b1;

    always_comb begin
        st_d = st_q;
        if (bmc_we) begin
            st_d.mem[bmc_idx] = bmc_byte;
        end
        if (load) begin
            st_d.len = (load_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : load_len;
            st_d.ptr = '0;
        end else if (rewind) begin
            st_d.ptr = '0;
        end else if (pop && avail) begin
            if (ptr_inc == st_q.len) begin
                st_d.ptr = '0;
                st_d.len = '0;
            end else begin
                st_d.ptr = ptr_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_byte = avail ? st_q.mem[st_q.ptr[IDX_W-1:0]] : IDLE_BYTE;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= LEN_W'(DEPTH)) else $error("length over depth"); // R4
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.len == '0) |-> (st_q.ptr == '0)) else $error("stale pointer"); // R4
    AST_PTR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.len != '0) |-> (st_q.ptr < st_q.len)) else $error("pointer past end"); // R4
endmodule

// File: rtl/bt_flag_regs.sv
module bt_flag_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       mask_we,
    input  logic [7:0] wdata,
    input  logic       rsp_done,
    input  logic       evt_raise,
    output logic [7:0] ctrl_byte,
    output logic [7:0] mask_byte,
    output logic       clr_in,
    output logic       clr_out,
    output logic       irq,
    output logic       req_strobe
);
    import bt_pkg::*;

    typedef struct packed {
        logic rsp_atn;
        logic evt_atn;
        logic host_bsy;
        logic ctl_bsy;
        logic en;
        logic pend;
        logic req;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic spare_unused;

    assign spare_unused = wdata[5] ^ wdata[CB_CTL_BSY];

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (ctrl_we) begin
            if (wdata[CB_RSP_ATN])  st_d.rsp_atn  = 1'b0;
            if (wdata[CB_EVT_ATN])  st_d.evt_atn  = 1'b0;
            if (wdata[CB_HOST_BSY]) st_d.host_bsy = ~st_q.host_bsy;
            if (wdata[CB_HOST_GO]) begin
                st_d.ctl_bsy = 1'b1;
                st_d.req     = 1'b1;
            end
        end
        if (mask_we) begin
            if (wdata[MB_EN] != st_q.en) begin
                if (wdata[MB_EN]) begin
                    if (st_q.rsp_atn || st_q.evt_atn) st_d.pend = 1'b1;
                    st_d.en = 1'b1;
                end else begin
                    st_d.pend = 1'b0;
                    st_d.en   = 1'b0;
                end
            end
            if (wdata[MB_PEND] && st_d.pend) st_d.pend = 1'b0;
        end
        if (rsp_done) begin
            st_d.ctl_bsy = 1'b0;
            st_d.rsp_atn = 1'b1;
            if (st_d.en) st_d.pend = 1'b1;
        end
        if (evt_raise) begin
            st_d.evt_atn = 1'b1;
            if (st_d.en) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_byte  = {st_q.ctl_bsy, st_q.host_bsy, 1'b0, st_q.evt_atn,
                         st_q.rsp_atn, 3'b000};
    assign mask_byte  = {6'b0, st_q.pend, st_q.en};
    assign clr_in     = ctrl_we && wdata[CB_RST_IN];
    assign clr_out    = ctrl_we && wdata[CB_RST_OUT];
    assign irq        = st_q.pend;
    assign req_strobe = st_q.req;

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.en) else $error("pending without enable"); // R12
    AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> st_q.ctl_bsy) else $error("strobe without busy"); // R5
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !(ctrl_we && wdata[CB_HOST_GO])) |=> !st_q.req) else $error("strobe stretched"); // R5
    AST_HOST_BSY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[CB_HOST_BSY]) |=> (st_q.host_bsy != $past(st_q.host_bsy))) else $error("toggle missed"); // R7
    AST_ENABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && wdata[MB_EN] && !wdata[MB_PEND] && !st_q.en &&
         (st_q.rsp_atn || st_q.evt_atn)) |=> st_q.pend) else $error("late enable lost"); // R9
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && wdata[MB_PEND] && (wdata[MB_EN] == st_q.en) &&
         !rsp_done && !evt_raise) |=> !st_q.pend) else $error("pending not cleared"); // R10
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !mask_we) |=> !st_q.pend) else $error("event raised irq while disabled"); // R11
endmodule

// File: rtl/bt_host_window.sv
module bt_host_window #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned LEN_W = IDX_W + 1,
    localparam int unsigned CNT_W = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             irq_o,
    output logic             bmc_req_o,
    input  logic [IDX_W-1:0] bmc_ib_idx,
    output logic [7:0]       bmc_ib_byte,
    output logic [CNT_W-1:0] bmc_ib_count,
    input  logic             bmc_ob_we,
    input  logic [IDX_W-1:0] bmc_ob_idx,
    input  logic [7:0]       bmc_ob_byte,
    input  logic             bmc_rsp_valid,
    input  logic [LEN_W-1:0] bmc_rsp_len,
    input  logic             bmc_sms_set
);
    import bt_pkg::*;

    bt_ofs_e    ofs;
    logic       ctrl_we, mask_we, data_we, data_re;
    logic       clr_in, clr_out;
    logic [7:0] ctrl_byte, mask_byte, head_byte;

    assign ofs     = bt_ofs_e'(host_addr);
    assign ctrl_we = host_wr && (ofs == OFS_CTRL);
    assign mask_we = host_wr && (ofs == OFS_MASK);
    assign data_we = host_wr && (ofs == OFS_DATA);
    assign data_re = host_rd && (ofs == OFS_DATA);

    bt_flag_regs u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .mask_we    (mask_we),
        .wdata      (host_wdata),
        .rsp_done   (bmc_rsp_valid),
        .evt_raise  (bmc_sms_set),
        .ctrl_byte  (ctrl_byte),
        .mask_byte  (mask_byte),
        .clr_in     (clr_in),
        .clr_out    (clr_out),
        .irq        (irq_o),
        .req_strobe (bmc_req_o)
    );

    bt_ib_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ib (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_we),
        .wr_byte (host_wdata),
        .clr     (clr_in),
        .rd_idx  (bmc_ib_idx),
        .rd_byte (bmc_ib_byte),
        .count   (bmc_ib_count)
    );

    bt_ob_buf #(.DEPTH(DEPTH)) u_ob (
        .clk       (clk),
        .rst_n     (rst_n),
        .bmc_we    (bmc_ob_we),
        .bmc_idx   (bmc_ob_idx),
        .bmc_byte  (bmc_ob_byte),
        .load      (bmc_rsp_valid),
        .load_len  (bmc_rsp_len),
        .pop       (data_re),
        .rewind    (clr_out),
        .head_byte (head_byte)
    );

    always_comb begin
        unique case (ofs)
            OFS_CTRL: host_rdata = ctrl_byte;
            OFS_DATA: host_rdata = head_byte;
            OFS_MASK: host_rdata = mask_byte;
            default:  host_rdata = IDLE_BYTE;
        endcase
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd)) else $error("read and write together"); // R2
    AST_IRQ_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == mask_byte[MB_PEND]) else $error("irq differs from pending"); // R10
    AST_HOLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == OFS_NONE) |-> (host_rdata == IDLE_BYTE)) else $error("hole not idle"); // R2
endmodule

// File: tb/bt_host_window_tb_top.sv
module bt_host_window_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       irq_o, bmc_req_o;
    logic [5:0] bmc_ib_idx = '0;
    logic [7:0] bmc_ib_byte;
    logic [7:0] bmc_ib_count;
    logic       bmc_ob_we = 1'b0;
    logic [5:0] bmc_ob_idx = '0;
    logic [7:0] bmc_ob_byte = '0;
    logic       bmc_rsp_valid = 1'b0;
    logic [6:0] bmc_rsp_len = '0;
    logic       bmc_sms_set = 1'b0;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bt_host_window dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_o(irq_o), .bmc_req_o(bmc_req_o), .bmc_ib_idx(bmc_ib_idx),
        .bmc_ib_byte(bmc_ib_byte), .bmc_ib_count(bmc_ib_count),
        .bmc_ob_we(bmc_ob_we), .bmc_ob_idx(bmc_ob_idx), .bmc_ob_byte(bmc_ob_byte),
        .bmc_rsp_valid(bmc_rsp_valid), .bmc_rsp_len(bmc_rsp_len),
        .bmc_sms_set(bmc_sms_set)
    );

    // monitor: compares host read data against the scoreboard queue
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read: got %02h expected none", host_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (host_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", t, host_rdata, e);
                end
            end
        end
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", t, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic bmc_pulse_rsp(input logic [6:0] len);
        @(negedge clk);
        bmc_rsp_len = len; bmc_rsp_valid = 1'b1;
        @(negedge clk);
        bmc_rsp_valid = 1'b0;
    endtask

    task automatic bmc_pulse_sms();
        @(negedge clk);
        bmc_sms_set = 1'b1;
        @(negedge clk);
        bmc_sms_set = 1'b0;
    endtask

    task automatic bmc_put(input logic [5:0] i, input logic [7:0] d);
        @(negedge clk);
        bmc_ob_idx = i; bmc_ob_byte = d; bmc_ob_we = 1'b1;
        @(negedge clk);
        bmc_ob_we = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R2 hole
        chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
        hr(2'd0, 8'h00, "R1 control after reset");
        hr(2'd2, 8'h00, "R1 mask after reset");
        hr(2'd1, 8'hFF, "R1 empty data read");
        hr(2'd3, 8'hFF, "R2 hole read");

        // R3 inbound fill
        hw(2'd1, 8'hA1); hw(2'd1, 8'hB2); hw(2'd1, 8'hC3);
        chk("R3 count", bmc_ib_count, 8'd3);
        for (int i = 0; i < 3; i++) begin
            bmc_ib_idx = 6'(i);
            #1;
            chk("R3 stored byte", bmc_ib_byte, 8'hA1 + 8'(i) * 8'h11);
        end

        // R5 hand-over strobe and busy
        hw(2'd0, 8'h04);
        chk("R5 strobe high", {7'b0, bmc_req_o}, 8'h01);
        hr(2'd0, 8'h80, "R5 busy set and bits 0-2 read zero");
        chk("R5 strobe dropped", {7'b0, bmc_req_o}, 8'h00);

        // R3 clear inbound
        hw(2'd0, 8'h01);
        chk("R3 count cleared", bmc_ib_count, 8'd0);

        // R3 overrun
        for (int i = 0; i < 66; i++) hw(2'd1, 8'(i + 8'h40));
        chk("R3 overrun count", bmc_ib_count, 8'd66);
        bmc_ib_idx = 6'd63; #1;
        chk("R3 last slot", bmc_ib_byte, 8'(63 + 8'h40));
        bmc_ib_idx = 6'd0; #1;
        chk("R3 first slot kept", bmc_ib_byte, 8'h40);

        // R7 toggle
        hw(2'd0, 8'h40);
        hr(2'd0, 8'hC0, "R7 host busy set");
        hw(2'd0, 8'h40);
        hr(2'd0, 8'h80, "R7 host busy cleared");

        // R8 response, R11 no irq while disabled
        bmc_put(6'd0, 8'h11); bmc_put(6'd1, 8'h22); bmc_put(6'd2, 8'h33);
        bmc_pulse_rsp(7'd3);
        hr(2'd0, 8'h08, "R8 busy cleared attention set");
        chk("R11 irq off while disabled", {7'b0, irq_o}, 8'h00);

        // R4 drain with rewind
        hr(2'd1, 8'h11, "R4 byte 0");
        hr(2'd1, 8'h22, "R4 byte 1");
        hw(2'd0, 8'h02);
        hr(2'd1, 8'h11, "R4 byte 0 after rewind");
        hr(2'd1, 8'h22, "R4 byte 1 again");
        hr(2'd1, 8'h33, "R4 byte 2");
        hr(2'd1, 8'hFF, "R4 drained");

        // R9 late enable
        hw(2'd2, 8'h01);
        hr(2'd2, 8'h03, "R9 enable with attention pending");
        chk("R10 irq follows pending", {7'b0, irq_o}, 8'h01);
        // R10 clear pending
        hw(2'd2, 8'h03);
        hr(2'd2, 8'h01, "R10 pending cleared");
        chk("R10 irq dropped", {7'b0, irq_o}, 8'h00);
        hw(2'd2, 8'h03);
        hr(2'd2, 8'h01, "R10 clear with nothing pending");

        // R6 clears
        hw(2'd0, 8'h00);
        hr(2'd0, 8'h08, "R6 zero write keeps flags");
        hw(2'd0, 8'h08);
        hr(2'd0, 8'h00, "R6 response attention cleared");

        // R8/R11 event while enabled
        bmc_pulse_sms();
        hr(2'd0, 8'h10, "R8 event attention set");
        hr(2'd2, 8'h03, "R11 event raises pending");
        // R9 disable clears pending
        hw(2'd2, 8'h00);
        hr(2'd2, 8'h00, "R9 disable clears pending");
        chk("R9 irq low after disable", {7'b0, irq_o}, 8'h00);
        hw(2'd0, 8'h10);
        hr(2'd0, 8'h00, "R6 event attention cleared");
        bmc_pulse_sms();
        hr(2'd2, 8'h00, "R11 event while disabled");
        chk("R11 irq stays low", {7'b0, irq_o}, 8'h00);
        hw(2'd2, 8'h01);
        hr(2'd2, 8'h03, "R9 enable with event pending");

        // R2 write to hole ignored
        hw(2'd3, 8'hFF);
        hr(2'd0, 8'h10, "R2 hole write leaves control");
        hr(2'd2, 8'h03, "R2 hole write leaves mask");

        // R1 cold reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 irq after second reset", {7'b0, irq_o}, 8'h00);
        hr(2'd2, 8'h00, "R1 mask after second reset");
        hr(2'd0, 8'h00, "R1 control after second reset");

        finish_run();
    end
endmodule